// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits beside a shared memory array and keeps track of address reservations for a set of requesting contexts. Every request presents an address, a context identity made of a CPU index and a hardware thread index, a read/write flag and a locked qualifier. A locked read places a reservation for its context. A locked write is a conditional store. It is granted only while that same context still holds a reservation on the addressed granule. Any write, plain or conditional and whether it is granted or not, wipes every reservation on its granule.

The verdict is combinational. In the same cycle as a write request, the block drives the write-enable gate for the memory array, a done strobe with a 1/0 result for a conditional store, and a conflict flag for a plain store that landed on reserved data. Table updates take effect at the clock edge that ends the request cycle.

Each context owns one slot. The slot is a two-state machine. Its states are `RES_EMPTY` (no reservation) and `RES_HELD` (reservation on a stored granule tag). Its transitions are:
- **RESERVE**: `RES_EMPTY` to `RES_HELD`, on a locked read from the slot's own context.
- **RELOAD**: `RES_HELD` to `RES_HELD`, on a locked read from the own context; the tag is overwritten in place.
- **KILL**: `RES_HELD` to `RES_EMPTY`, on any write whose granule equals the stored tag.
- **IDLE**: the state is kept for every other request.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no context holds a reservation. With `req_valid` low, `mem_we`, `sc_done`, `sc_result` and `store_conflict` are all 0.
- R2: A locked read (`req_write`=0, `req_locked`=1) creates a reservation for its context. A conditional store from the same context to the same granule in the next cycle returns `sc_result`=1 with `sc_done`=1 and `mem_we`=1.
- R3: A read without the locked qualifier leaves every reservation unchanged. A conditional store after only a plain read fails.
- R4: Addresses are compared at granule size (GRAN_BYTES, 16 by default), so the low log2(GRAN_BYTES) address bits are ignored. Any byte inside the reserved granule matches, and an address in another granule does not.
- R5: A context holds at most one reservation. A second locked read from the same context moves the reservation to the new granule, so a conditional store to the old granule fails and one to the new granule succeeds.
- R6: Different contexts may hold reservations on the same granule at the same time. A locked read by one context does not remove another context's reservation.
- R7: A plain store (`req_write`=1, `req_locked`=0) always drives `mem_we`=1 and never raises `sc_done`.
- R8: A conditional store (`req_write`=1, `req_locked`=1) fails unless its own context holds a reservation on the addressed granule. A reservation held by a different context does not count. On failure `sc_result`=0 and `mem_we`=0.
- R9: Every store, whether plain, a granted conditional or a refused conditional, clears the reservations of all contexts on the addressed granule. Reservations on other granules survive.
- R10: `store_conflict` is 1 exactly when a valid plain store addresses a granule that at least one context holds.
- R11: All outputs respond combinationally in the request cycle. Reservation changes are visible to the request in the following cycle.
- R12: The context identity is {`req_cpu`, `req_thread`}. Two threads of the same CPU are separate contexts with independent reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked qualifier: reserving load or conditional store |
| req_addr | input | ADDR_W (32) | Byte address |
| req_cpu | input | CPU_W (2) | CPU index, upper part of the context identity |
| req_thread | input | THR_W (1) | Hardware thread index, lower part of the context identity |
| mem_we | output | 1 | Write-enable gate toward the memory array |
| sc_done | output | 1 | A conditional store is being answered this cycle |
| sc_result | output | 1 | Conditional store outcome: 1 granted, 0 refused |
| store_conflict | output | 1 | A plain store hit a reserved granule |

## Verification
The hardest situation to reach is the moment when several slots hold the same granule and a single store must clear all of them together, including the requester's own slot after it was granted. Reservations can only be seen at the ports by consuming them, so the stimulus builds the shared state from locked reads by two or more contexts. It then fires one store and probes each former holder with a conditional store, which must now be refused. Selective survival is checked the same way: a store to a neighbouring granule is followed by a granted conditional store on the untouched reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Per-context reservation slot state.
    typedef enum logic {
        RES_EMPTY = 1'b0,
        RES_HELD  = 1'b1
    } res_state_e;

endpackage

// File: rtl/llsc_slot.sv
module llsc_slot
    import llsc_pkg::*;
#(
    parameter int TAG_W   = 28,
    parameter int CTX_W   = 3,
    parameter int SLOT_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_locked,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [CTX_W-1:0] req_ctx,
    output logic             held,
    output logic             hit
);

    res_state_e       state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             own_ctx;
    logic             reserve_req;
    logic             write_req;

    always_comb begin
        own_ctx     = (req_ctx == CTX_W'(SLOT_ID));
        reserve_req = req_valid && !req_write && req_locked && own_ctx;
        write_req   = req_valid && req_write;
        held        = (state_q == RES_HELD);
        hit         = held && (tag_q == req_tag);
    end

    // Next-state: RESERVE, RELOAD, KILL, IDLE
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            RES_EMPTY: begin
                if (reserve_req) begin
                    state_d = RES_HELD;
                    tag_d   = req_tag;
                end
            end
            RES_HELD: begin
                if (reserve_req) begin
                    tag_d = req_tag;
                end else if (write_req && hit) begin
                    state_d = RES_EMPTY;
                end
            end
            default: state_d = RES_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RES_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    // R2: a slot only becomes held after a locked read from its own context
    p_hold_from_lr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(req_valid && !req_write && req_locked && own_ctx));

    // R9: a write to the held granule empties the slot
    p_kill_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && hit && !$isunknown(req_tag)) |=> !held);

endmodule

// File: rtl/llsc_resolve.sv
module llsc_resolve #(
    parameter int CTX_W = 3,
    localparam int N_CTX = 1 << CTX_W
) (
    input  logic [N_CTX-1:0] hit_vec,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_locked,
    input  logic [CTX_W-1:0] req_ctx,
    output logic             mem_we,
    output logic             sc_done,
    output logic             sc_result,
    output logic             store_conflict
);

    logic cond_store;
    logic plain_store;
    logic grant;

    always_comb begin
        cond_store     = req_valid && req_write && req_locked;
        plain_store    = req_valid && req_write && !req_locked;
        grant          = cond_store && hit_vec[req_ctx];
        sc_done        = cond_store;
        sc_result      = grant;
        mem_we         = plain_store || grant;
        store_conflict = plain_store && (|hit_vec);
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int ADDR_W     = 32,
    parameter int CPU_W      = 2,
    parameter int THR_W      = 1,
    parameter int GRAN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_locked,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thread,
    output logic              mem_we,
    output logic              sc_done,
    output logic              sc_result,
    output logic              store_conflict
);

    localparam int GRAN_LSB = $clog2(GRAN_BYTES);
    localparam int TAG_W    = ADDR_W - GRAN_LSB;
    localparam int CTX_W    = CPU_W + THR_W;
    localparam int N_CTX    = 1 << CTX_W;

    logic [TAG_W-1:0] req_tag;
    logic [CTX_W-1:0] req_ctx;
    logic [N_CTX-1:0] held_vec;
    logic [N_CTX-1:0] hit_vec;

    assign req_tag = req_addr[ADDR_W-1:GRAN_LSB];
    assign req_ctx = {req_cpu, req_thread};

    for (genvar g = 0; g < N_CTX; g++) begin : g_slot
        llsc_slot #(
            .TAG_W  (TAG_W),
            .CTX_W  (CTX_W),
            .SLOT_ID(g)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid),
            .req_write (req_write),
            .req_locked(req_locked),
            .req_tag   (req_tag),
            .req_ctx   (req_ctx),
            .held      (held_vec[g]),
            .hit       (hit_vec[g])
        );
    end

    llsc_resolve #(
        .CTX_W(CTX_W)
    ) u_resolve (
        .hit_vec       (hit_vec),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_locked    (req_locked),
        .req_ctx       (req_ctx),
        .mem_we        (mem_we),
        .sc_done       (sc_done),
        .sc_result     (sc_result),
        .store_conflict(store_conflict)
    );

    // R7: plain stores always reach memory
    p_plain_store_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_locked) |-> (mem_we && !sc_done));

    // R8: no own reservation means a refused conditional store
    p_sc_needs_own_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !held_vec[req_ctx]) |-> (!sc_result && !mem_we));

    // R3: ordinary reads leave the table untouched
    p_read_keeps_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_locked) |=> (held_vec == $past(held_vec)));

    // R10: conflict flag only on plain stores
    p_conflict_plain_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        store_conflict |-> (req_valid && req_write && !req_locked));

    // R1: nothing held right after reset
    p_reset_empty_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (held_vec == '0));

endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_locked = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_cpu = '0;
    logic [0:0]  req_thread = '0;
    logic        mem_we, sc_done, sc_result, store_conflict;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    llsc_monitor uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_locked(req_locked), .req_addr(req_addr), .req_cpu(req_cpu),
        .req_thread(req_thread), .mem_we(mem_we), .sc_done(sc_done),
        .sc_result(sc_result), .store_conflict(store_conflict)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one request for one cycle; sample outputs mid-cycle.
    task automatic op(input logic w, input logic l, input logic [31:0] a,
                      input logic [1:0] cpu, input logic thr,
                      output logic o_we, output logic o_done,
                      output logic o_res, output logic o_conf);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_locked = l;
        req_addr = a; req_cpu = cpu; req_thread = thr;
        #4;
        o_we = mem_we; o_done = sc_done; o_res = sc_result; o_conf = store_conflict;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic lr(input logic [31:0] a, input logic [1:0] cpu, input logic thr);
        logic we, dn, rs, cf;
        op(1'b0, 1'b1, a, cpu, thr, we, dn, rs, cf);
    endtask

    task automatic prd(input logic [31:0] a, input logic [1:0] cpu, input logic thr);
        logic we, dn, rs, cf;
        op(1'b0, 1'b0, a, cpu, thr, we, dn, rs, cf);
    endtask

    task automatic sc(input string tag, input logic [31:0] a, input logic [1:0] cpu,
                      input logic thr, input int exp_res);
        logic we, dn, rs, cf;
        op(1'b1, 1'b1, a, cpu, thr, we, dn, rs, cf);
        chk({tag, " sc_done"}, dn, 1);
        chk({tag, " sc_result"}, rs, exp_res);
        chk({tag, " mem_we"}, we, exp_res);
    endtask

    task automatic st(input string tag, input logic [31:0] a, input logic [1:0] cpu,
                      input logic thr, input int exp_conf);
        logic we, dn, rs, cf;
        op(1'b1, 1'b0, a, cpu, thr, we, dn, rs, cf);
        chk({tag, " R7 mem_we"}, we, 1);
        chk({tag, " R7 sc_done"}, dn, 0);
        chk({tag, " R10 conflict"}, cf, exp_conf);
    endtask

    task automatic t_reset;
        #2;
        chk("R1 idle mem_we", mem_we, 0);
        chk("R1 idle sc_done", sc_done, 0);
        chk("R1 idle sc_result", sc_result, 0);
        chk("R1 idle conflict", store_conflict, 0);
        sc("R1 sc after reset", 32'h100, 2'd0, 1'b0, 0);
    endtask

    task automatic t_basic;
        lr(32'h200, 2'd1, 1'b0);
        sc("R2 R11 sc next cycle", 32'h200, 2'd1, 1'b0, 1);
        sc("R9 own cleared after grant", 32'h200, 2'd1, 1'b0, 0);
    endtask

    task automatic t_plain_read;
        prd(32'h300, 2'd2, 1'b0);
        sc("R3 plain read no reserve", 32'h300, 2'd2, 1'b0, 0);
        lr(32'h310, 2'd2, 1'b0);
        prd(32'h310, 2'd2, 1'b0);
        sc("R3 plain read keeps reserve", 32'h310, 2'd2, 1'b0, 1);
    endtask

    task automatic t_granule;
        lr(32'h404, 2'd3, 1'b0);
        sc("R4 other byte same granule", 32'h40C, 2'd3, 1'b0, 1);
        lr(32'h404, 2'd3, 1'b0);
        sc("R4 next granule misses", 32'h414, 2'd3, 1'b0, 0);
        sc("R9 other granule survives", 32'h400, 2'd3, 1'b0, 1);
    endtask

    task automatic t_replace;
        lr(32'h500, 2'd0, 1'b1);
        lr(32'h600, 2'd0, 1'b1);
        sc("R5 old granule dropped", 32'h500, 2'd0, 1'b1, 0);
        sc("R5 new granule held", 32'h600, 2'd0, 1'b1, 1);
    endtask

    task automatic t_shared;
        lr(32'h700, 2'd2, 1'b1);
        lr(32'h700, 2'd3, 1'b1);
        sc("R6 first holder kept", 32'h708, 2'd2, 1'b1, 1);
        sc("R9 grant wipes other ctx", 32'h700, 2'd3, 1'b1, 0);
    endtask

    task automatic t_other_ctx;
        lr(32'h800, 2'd0, 1'b0);
        sc("R8 foreign reservation", 32'h800, 2'd0, 1'b1, 0);
        sc("R9 refused sc wipes", 32'h800, 2'd0, 1'b0, 0);
    endtask

    task automatic t_plain_store;
        lr(32'h900, 2'd1, 1'b1);
        st("R10 hit", 32'h904, 2'd3, 1'b1, 1);
        sc("R9 plain store wipes", 32'h900, 2'd1, 1'b1, 0);
        st("R10 miss", 32'hA00, 2'd1, 1'b1, 0);
    endtask

    task automatic t_ctx_id;
        lr(32'hB00, 2'd1, 1'b0);
        lr(32'hB40, 2'd1, 1'b1);
        sc("R12 thread0 own", 32'hB00, 2'd1, 1'b0, 1);
        sc("R12 thread1 own", 32'hB40, 2'd1, 1'b1, 1);
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_basic;
        t_plain_read;
        t_granule;
        t_replace;
        t_shared;
        t_other_ctx;
        t_plain_store;
        t_ctx_id;
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule